// File: doc/BRIEF.md
# Wide-Word Pixel Fetch Controller

This block sits between a single wide memory port and two users: a display path that needs one 8-bit pixel on every clock, and a host that reads and writes single pixels. Each memory word holds several pixels (two or four, chosen by a parameter). The display side reads a whole word in one access and presents its pixels on consecutive cycles. The memory is therefore idle on most cycles, and the host uses those spare cycles.

A host write names one byte by its byte address. It is applied to the wide word in one of two ways, chosen per access. The first is a single write cycle with byte strobes. The second is a read of the word followed by a full-word write that carries the merged byte. The host holds its request until a one-cycle ready pulse marks that the access is complete. Video timing is generated elsewhere. This block only follows a streaming enable and a start word address.

Top module: `pixwide_ctrl`

## Requirements
- R1: After reset, pix_valid, host_ready and mem_req are all low while vid_en and host_req are low.
- R2: Pixels of a word are presented least significant byte first, with byte k (bits 8k+7..8k) in the k-th cycle of that word, one pixel per clock.
- R3: The first pixel appears on the second clock edge after vid_en is first sampled high. While vid_en stays high the stream has no gaps, because the next word is fetched in the cycle that shows pixel index N-2 of the current word.
- R4: Words are fetched from consecutive addresses starting at vid_base. Sampling vid_en low clears pix_valid at the next edge, and the next stream starts again from vid_base.
- R5: A host byte address splits into a lane (its low log2(N) bits) and a word address (the remaining upper bits).
- R6: In strobe mode (host_rmw = 0) a write uses one memory cycle. mem_be has only the lane bit set and mem_wdata carries the byte in every lane. host_ready pulses one cycle after the write is issued.
- R7: In merge mode (host_rmw = 1) a write issues a read of the word and then, in the very next cycle, a write with mem_be all ones. The other bytes of the word are kept. host_ready pulses the cycle after the write.
- R8: A host read returns the addressed byte on host_rdata, with host_ready pulsing two cycles after the read is issued.
- R9: The display fetch has priority over the host. The host is never granted the port in a cycle in which the display side fetches.
- R10: A merge-mode write starts only when the display side will not fetch in the following cycle. Host traffic of any kind never causes a gap in the pixel stream.
- R11: host_ready is a single-cycle pulse, and a new host access is accepted only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_en | input | 1 | Stream enable for the display side |
| vid_base | input | ADDR_W | Word address where a stream starts |
| pix_valid | output | 1 | pix_data holds a pixel this cycle |
| pix_data | output | PIX_W | Current pixel |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_rmw | input | 1 | Write method: 1 = read-merge-write, 0 = byte strobes |
| host_addr | input | ADDR_W+log2(N) | Host byte address |
| host_wdata | input | PIX_W | Byte to write |
| host_rdata | output | PIX_W | Byte read |
| host_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | N | Byte strobes for writes |
| mem_wdata | output | N*PIX_W | Write word |
| mem_rdata | input | N*PIX_W | Read word, valid the cycle after a read |

## Verification
The assertions check three things on every cycle: the display and host never own the port together, a merge write always directly follows its read, and a strobe write sets one lane. They also check that the stream never drops at a word boundary, that a host lock never covers a due fetch, and that ready is a single pulse. The scenarios are needed to show the pixel order and values, the start-up delay and the restart address. They also show the lane steering, that neighbour bytes survive a merge write, the host latencies, and the stream staying intact while host traffic runs under it.

// File: rtl/pixwide_pkg.sv
`timescale 1ns/1ps
package pixwide_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_READ  = 2'd1,
    HS_MERGE = 2'd2,
    HS_DONE  = 2'd3
  } host_state_e;
endpackage

// File: rtl/pixwide_fetch.sv
`timescale 1ns/1ps
module pixwide_fetch #(
  parameter int unsigned PIX_PER_WORD = 4,
  parameter int unsigned PIX_W        = 8,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vid_en,
  input  logic [ADDR_W-1:0]             vid_base,
  input  logic                          lock,
  input  logic [PIX_PER_WORD*PIX_W-1:0] mem_rdata,
  output logic                          vreq,
  output logic [ADDR_W-1:0]             vaddr,
  output logic                          due_next,
  output logic                          pix_valid,
  output logic [PIX_W-1:0]              pix_data
);
  localparam int unsigned WORD_W = PIX_PER_WORD * PIX_W;
  localparam int unsigned LANE_W = $clog2(PIX_PER_WORD);
  localparam logic [LANE_W-1:0] IDX_LAST = LANE_W'(PIX_PER_WORD - 1);
  localparam logic [LANE_W-1:0] IDX_PRE  = LANE_W'(PIX_PER_WORD - 2);

  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] idx_q, idx_d, idx_succ;
  logic              wvalid_q, wvalid_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_en;

  // fetch decision and next state
  always_comb begin
    idx_succ = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    vreq     = vid_en && !lock && !pend_q && (!wvalid_q || idx_q == IDX_PRE);
    due_next = vid_en && ((pend_q && (IDX_PRE == '0)) ||
                          (wvalid_q && !pend_q && idx_succ == IDX_PRE));
    load_en  = vid_en && pend_q;
    pend_d   = vreq;
    addr_d   = addr_q;
    wvalid_d = wvalid_q;
    idx_d    = idx_q;
    if (!vid_en) begin
      addr_d   = vid_base;
      wvalid_d = 1'b0;
      idx_d    = '0;
    end else begin
      if (vreq) addr_d = addr_q + 1'b1;
      if (pend_q) begin
        wvalid_d = 1'b1;
        idx_d    = '0;
      end else if (wvalid_q) begin
        if (idx_q == IDX_LAST) wvalid_d = 1'b0;
        else                   idx_d    = idx_succ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      wvalid_q <= 1'b0;
      pend_q   <= 1'b0;
      addr_q   <= '0;
    end else begin
      idx_q    <= idx_d;
      wvalid_q <= wvalid_d;
      pend_q   <= pend_d;
      addr_q   <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= mem_rdata;
  end

  assign vaddr     = addr_q;
  assign pix_valid = wvalid_q;
  assign pix_data  = word_q[idx_q*PIX_W +: PIX_W];

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && wvalid_q && idx_q == IDX_LAST) |=> pix_valid)
    else $error("stream gap at word boundary"); // R3

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_en) |=> !pix_valid)
    else $error("pixel valid after stream stop"); // R4

  AST_LOCK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !(vid_en && wvalid_q && !pend_q && idx_q == IDX_PRE))
    else $error("host lock over a due fetch"); // R10
endmodule

// File: rtl/pixwide_host.sv
`timescale 1ns/1ps
module pixwide_host
  import pixwide_pkg::*;
#(
  parameter int unsigned PIX_PER_WORD = 4,
  parameter int unsigned PIX_W        = 8,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  host_req,
  input  logic                                  host_we,
  input  logic                                  host_rmw,
  input  logic [ADDR_W+$clog2(PIX_PER_WORD)-1:0] host_addr,
  input  logic [PIX_W-1:0]                      host_wdata,
  input  logic                                  vreq,
  input  logic                                  due_next,
  input  logic [PIX_PER_WORD*PIX_W-1:0]         mem_rdata,
  output logic                                  hreq,
  output logic                                  hwe,
  output logic [ADDR_W-1:0]                     haddr,
  output logic [PIX_PER_WORD-1:0]               hbe,
  output logic [PIX_PER_WORD*PIX_W-1:0]         hwdata,
  output logic                                  lock,
  output logic [PIX_W-1:0]                      host_rdata,
  output logic                                  host_ready
);
  localparam int unsigned WORD_W = PIX_PER_WORD * PIX_W;
  localparam int unsigned LANE_W = $clog2(PIX_PER_WORD);

  host_state_e       state_q, state_d;
  logic [LANE_W-1:0] lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PIX_W-1:0]  data_q, rdata_q;
  logic [LANE_W-1:0] lane_in;
  logic [ADDR_W-1:0] word_in;
  logic [PIX_PER_WORD-1:0] lane_hot;
  logic [WORD_W-1:0] merged;
  logic              start, want_rmw, strobe_wr, cap_en, rd_en;

  assign lane_in = host_addr[LANE_W-1:0];
  assign word_in = host_addr[ADDR_W+LANE_W-1:LANE_W];

  for (genvar g = 0; g < PIX_PER_WORD; g++) begin : g_lane
    assign lane_hot[g] = (lane_in == LANE_W'(g));
    assign merged[g*PIX_W +: PIX_W] = (lane_q == LANE_W'(g)) ? data_q
                                     : mem_rdata[g*PIX_W +: PIX_W];
  end

  always_comb begin
    want_rmw  = host_we && host_rmw;
    start     = (state_q == HS_IDLE) && host_req && !vreq && (!want_rmw || !due_next);
    strobe_wr = start && host_we && !host_rmw;
    cap_en    = start;
    rd_en     = (state_q == HS_READ);
    lock      = (state_q == HS_MERGE);
    if (state_q == HS_MERGE) begin
      hreq   = 1'b1;
      hwe    = 1'b1;
      haddr  = addr_q;
      hbe    = '1;
      hwdata = merged;
    end else begin
      hreq   = start;
      hwe    = strobe_wr;
      haddr  = word_in;
      hbe    = strobe_wr ? lane_hot : '0;
      hwdata = {PIX_PER_WORD{host_wdata}};
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (start) state_d = !host_we ? HS_READ : (host_rmw ? HS_MERGE : HS_DONE);
      HS_READ:  state_d = HS_DONE;
      HS_MERGE: state_d = HS_DONE;
      HS_DONE:  state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      lane_q <= lane_in;
      addr_q <= word_in;
      data_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mem_rdata[lane_q*PIX_W +: PIX_W];
  end

  assign host_rdata = rdata_q;
  assign host_ready = (state_q == HS_DONE);

  AST_MERGE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_MERGE) |-> $past(hreq && !hwe))
    else $error("merge write without preceding read"); // R7

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && hwe && hbe != '1) |-> ($countones(hbe) == 1))
    else $error("strobe write touches more than one lane"); // R6

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready)
    else $error("ready longer than one cycle"); // R11
endmodule

// File: rtl/pixwide_arb.sv
`timescale 1ns/1ps
module pixwide_arb #(
  parameter int unsigned PIX_PER_WORD = 4,
  parameter int unsigned PIX_W        = 8,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vreq,
  input  logic [ADDR_W-1:0]             vaddr,
  input  logic                          hreq,
  input  logic                          hwe,
  input  logic [ADDR_W-1:0]             haddr,
  input  logic [PIX_PER_WORD-1:0]       hbe,
  input  logic [PIX_PER_WORD*PIX_W-1:0] hwdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [PIX_PER_WORD-1:0]       mem_be,
  output logic [PIX_PER_WORD*PIX_W-1:0] mem_wdata
);
  always_comb begin
    mem_req   = vreq || hreq;
    mem_wdata = hwdata;
    if (vreq) begin
      mem_we   = 1'b0;
      mem_addr = vaddr;
      mem_be   = '0;
    end else begin
      mem_we   = hreq && hwe;
      mem_addr = haddr;
      mem_be   = hreq ? hbe : '0;
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(vreq && hreq))
    else $error("display and host own the port together"); // R9
endmodule

// File: rtl/pixwide_ctrl.sv
`timescale 1ns/1ps
module pixwide_ctrl #(
  parameter int unsigned PIX_PER_WORD = 4,
  parameter int unsigned PIX_W        = 8,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   vid_en,
  input  logic [ADDR_W-1:0]                      vid_base,
  output logic                                   pix_valid,
  output logic [PIX_W-1:0]                       pix_data,
  input  logic                                   host_req,
  input  logic                                   host_we,
  input  logic                                   host_rmw,
  input  logic [ADDR_W+$clog2(PIX_PER_WORD)-1:0] host_addr,
  input  logic [PIX_W-1:0]                       host_wdata,
  output logic [PIX_W-1:0]                       host_rdata,
  output logic                                   host_ready,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-1:0]                      mem_addr,
  output logic [PIX_PER_WORD-1:0]                mem_be,
  output logic [PIX_PER_WORD*PIX_W-1:0]          mem_wdata,
  input  logic [PIX_PER_WORD*PIX_W-1:0]          mem_rdata
);
  localparam int unsigned WORD_W = PIX_PER_WORD * PIX_W;

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               vreq, due_next, lock;
  logic [ADDR_W-1:0]  vaddr, haddr;
  logic               hreq, hwe;
  logic [PIX_PER_WORD-1:0] hbe;
  logic [WORD_W-1:0]  hwdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pixwide_fetch #(.PIX_PER_WORD(PIX_PER_WORD), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .vid_en(vid_en), .vid_base(vid_base), .lock(lock),
    .mem_rdata(mem_rdata), .vreq(vreq), .vaddr(vaddr), .due_next(due_next),
    .pix_valid(pix_valid), .pix_data(pix_data)
  );

  pixwide_host #(.PIX_PER_WORD(PIX_PER_WORD), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_int_n), .host_req(host_req), .host_we(host_we),
    .host_rmw(host_rmw), .host_addr(host_addr), .host_wdata(host_wdata),
    .vreq(vreq), .due_next(due_next), .mem_rdata(mem_rdata),
    .hreq(hreq), .hwe(hwe), .haddr(haddr), .hbe(hbe), .hwdata(hwdata),
    .lock(lock), .host_rdata(host_rdata), .host_ready(host_ready)
  );

  pixwide_arb #(.PIX_PER_WORD(PIX_PER_WORD), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_int_n), .vreq(vreq), .vaddr(vaddr), .hreq(hreq), .hwe(hwe),
    .haddr(haddr), .hbe(hbe), .hwdata(hwdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!vid_en && !host_req && !host_ready && !lock) |-> !mem_req)
    else $error("memory access with no user"); // R1
endmodule

// File: tb/pixwide_ctrl_test.sv
`timescale 1ns/1ps
module pixwide_ctrl_test;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic vid_en;
  logic [AW-1:0] vid_base;
  logic pix_valid;
  logic [PW-1:0] pix_data;
  logic host_req, host_we, host_rmw;
  logic [AW+1:0] host_addr;
  logic [PW-1:0] host_wdata, host_rdata;
  logic host_ready;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [N-1:0] mem_be;
  logic [N*PW-1:0] mem_wdata, mem_rdata;

  logic [N*PW-1:0] mem [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;
  int gap_cnt = 0;
  int pix_cnt = 0;
  bit seen = 0;
  int ptr = 0;
  bit wr_seen, rmw_ok, prev_rd;
  logic [N-1:0] wr_be;
  logic [N*PW-1:0] wr_data;
  logic [AW-1:0] wr_addr, prev_rd_addr;

  always #4 clk = ~clk;

  pixwide_ctrl #(.PIX_PER_WORD(N), .PIX_W(PW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .vid_base(vid_base),
    .pix_valid(pix_valid), .pix_data(pix_data), .host_req(host_req),
    .host_we(host_we), .host_rmw(host_rmw), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency, byte strobes on write
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < N; k++)
          if (mem_be[k]) mem[mem_addr][k*PW +: PW] <= mem_wdata[k*PW +: PW];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  function automatic logic [7:0] get_byte(int b);
    return mem[(b >> 2) & 255][(b & 3)*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pixel monitor, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1) begin
      if (!vid_en) begin
        ptr  = int'(vid_base) * 4;
        seen = 0;
      end else if (pix_valid) begin
        chk(pix_data == get_byte(ptr), "R2 pixel value", int'(pix_data), int'(get_byte(ptr)));
        ptr++;
        pix_cnt++;
        seen = 1;
      end else if (seen) begin
        gap_cnt++;
      end
    end
  end

  // memory port monitor, sampled between edges
  always @(negedge clk) begin
    #1;
    if (mem_req && mem_we) begin
      wr_seen = 1;
      wr_be   = mem_be;
      wr_data = mem_wdata;
      wr_addr = mem_addr;
      if (mem_be == '1 && prev_rd && prev_rd_addr == mem_addr) rmw_ok = 1;
    end
    prev_rd      = mem_req && !mem_we;
    prev_rd_addr = mem_addr;
  end

  task automatic host_op(input logic we, input logic rmw, input logic [AW+1:0] a,
                         input logic [7:0] d, output logic [7:0] rd, output int lat);
    @(negedge clk);
    wr_seen = 0; rmw_ok = 0;
    host_req = 1; host_we = we; host_rmw = rmw; host_addr = a; host_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ready && lat < 50);
    rd = host_rdata;
    host_req = 0;
    @(negedge clk);
    chk(host_ready == 1'b0, "R11 ready single pulse", int'(host_ready), 0);
  endtask

  task automatic t_reset;
    chk(pix_valid == 1'b0, "R1 pix_valid after reset", int'(pix_valid), 0);
    chk(host_ready == 1'b0, "R1 host_ready after reset", int'(host_ready), 0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);
  endtask

  task automatic t_stream(input int base);
    gap_cnt = 0; pix_cnt = 0;
    @(negedge clk);
    vid_base = AW'(base);
    @(negedge clk);
    vid_en = 1;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R3 no pixel one edge after enable", int'(pix_valid), 0);
    @(negedge clk);
    chk(pix_valid == 1'b1, "R3 first pixel two edges after enable", int'(pix_valid), 1);
    chk(pix_data == get_byte(base*4), "R4 first pixel from vid_base", int'(pix_data), int'(get_byte(base*4)));
    repeat (22) @(negedge clk);
    vid_en = 0;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R4 stop clears valid", int'(pix_valid), 0);
    chk(gap_cnt == 0, "R3 no gaps in stream", gap_cnt, 0);
    chk(pix_cnt >= 20, "R3 pixel count", pix_cnt, 20);
  endtask

  task automatic t_read_idle;
    logic [7:0] rd; int lat;
    host_op(1'b0, 1'b0, {8'd50, 2'd3}, 8'h00, rd, lat);
    chk(rd == get_byte(50*4+3), "R8 R5 read byte lane 3", int'(rd), int'(get_byte(50*4+3)));
    chk(lat == 2, "R8 read latency", lat, 2);
  endtask

  task automatic t_strobe_write;
    logic [7:0] rd; int lat; logic [31:0] expw;
    expw = mem[60];
    expw[23:16] = 8'hA5;
    host_op(1'b1, 1'b0, {8'd60, 2'd2}, 8'hA5, rd, lat);
    chk(lat == 1, "R6 strobe write latency", lat, 1);
    chk(wr_seen && wr_be == 4'b0100, "R6 R5 lane 2 strobe", int'(wr_be), 4);
    chk(wr_data == {4{8'hA5}}, "R6 byte replicated", int'(wr_data), int'({4{8'hA5}}));
    chk(mem[60] == expw, "R6 word after strobe write", int'(mem[60]), int'(expw));
  endtask

  task automatic t_merge_write;
    logic [7:0] rd; int lat; logic [31:0] expw;
    expw = mem[70];
    expw[7:0] = 8'h3C;
    host_op(1'b1, 1'b1, {8'd70, 2'd0}, 8'h3C, rd, lat);
    chk(lat == 2, "R7 merge write latency", lat, 2);
    chk(rmw_ok == 1'b1, "R7 read then full write", int'(rmw_ok), 1);
    chk(wr_be == 4'b1111, "R7 full strobes", int'(wr_be), 15);
    chk(mem[70] == expw, "R7 neighbours kept", int'(mem[70]), int'(expw));
  endtask

  task automatic t_host_under_stream;
    logic [7:0] rd; int lat; logic [31:0] expw;
    gap_cnt = 0;
    @(negedge clk);
    vid_base = 8'd20;
    vid_en = 1;
    repeat (3) @(negedge clk);
    expw = mem[110];
    expw[15:8] = 8'h77;
    host_op(1'b1, 1'b1, {8'd110, 2'd1}, 8'h77, rd, lat);
    chk(lat <= 8, "R10 merge write completes under stream", lat, 8);
    chk(rmw_ok == 1'b1, "R10 merge pair unbroken", int'(rmw_ok), 1);
    chk(mem[110] == expw, "R10 merged word", int'(mem[110]), int'(expw));
    expw = mem[111];
    expw[31:24] = 8'h81;
    host_op(1'b1, 1'b0, {8'd111, 2'd3}, 8'h81, rd, lat);
    chk(lat <= 4, "R9 strobe write in free slot", lat, 4);
    chk(mem[111] == expw, "R9 strobe word under stream", int'(mem[111]), int'(expw));
    host_op(1'b0, 1'b0, {8'd112, 2'd0}, 8'h00, rd, lat);
    chk(rd == get_byte(112*4), "R9 read under stream", int'(rd), int'(get_byte(112*4)));
    repeat (5) @(negedge clk);
    vid_en = 0;
    @(negedge clk);
    chk(gap_cnt == 0, "R10 no gaps with host traffic", gap_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++)
      for (int k = 0; k < N; k++)
        mem[i][k*PW +: PW] = 8'((i*N + k) * 37 + 11);
    mem_rdata = '0;
    rst_n = 0; vid_en = 0; vid_base = '0;
    host_req = 0; host_we = 0; host_rmw = 0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stream(5);
    t_stream(60);
    t_read_idle();
    t_strobe_write();
    t_merge_write();
    t_host_under_stream();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule